// File: doc/BRIEF.md
# Masked Packed Single-Precision Less-Than Comparator

This block compares two packed vectors of IEEE-754 single-precision numbers lane by lane. The lane count is a parameter and may be 4, 8 or 16. In every lane the unit asks whether operand A is strictly smaller than operand B. The test is ordered, so any NaN makes the answer false. It is also quiet, so a quiet NaN raises nothing. A signalling NaN in a lane that takes part sets an invalid-operation flag. Operand B can be replaced in every lane by one broadcast 32-bit scalar.

A destination select picks between two result forms. The vector form fills each 32-bit result lane with all ones or all zeros. The mask form writes one bit per lane into a 16-bit mask and clears every mask bit above the lane count. In the mask form an optional zeroing write-mask removes lanes from the compare. A suppress-exceptions input holds the invalid flag low, but only in the 16-lane build. The caller supplies an 8-bit predicate code, and only the code for this predicate starts a compare.

Results are registered. A small two-state controller owns the output valid. In state `ST_IDLE` (out_valid low) it moves to `ST_RESULT` on a cycle with `in_valid`, and otherwise it stays. In `ST_RESULT` (out_valid high) it stays on a further `in_valid` and returns to `ST_IDLE` when there is none. Result registers load only on cycles with `in_valid` and keep their value otherwise.

Top module: `fp32_vec_lt_cmp`

## Requirements
- R1: A lane result is true exactly when A < B numerically. This covers infinities and exact denormal values, so there is no flush to zero. Negative values order by reversed magnitude.
- R2: With `mask_mode`=0, bits [32i+31:32i] of `vec_res` are all ones for a true lane i and all zeros otherwise, and `mask_res` is zero.
- R3: With `mask_mode`=1, bit i of `mask_res` is the result of lane i, and `vec_res` is zero.
- R4: With `mask_mode`=1 and `wmask_en`=1, a lane whose `wmask` bit i is 0 is not compared. Its mask bit is 0 and it cannot set `inv_flag`. With `wmask_en`=0 all lanes take part. In the vector form `wmask` has no effect.
- R5: `mask_res` bits from LANES up to 15 are always zero.
- R6: If either operand of a lane is a NaN (exponent all ones, fraction non-zero), the lane result is false.
- R7: +0 and -0 compare equal, so neither is less than the other.
- R8: `out_valid` is high in the cycle after each cycle with `in_valid` and low after a cycle without it. Results change only after cycles with `in_valid` and hold otherwise.
- R9: With `bcst_en`=1, every lane uses `bcst_val` as operand B and `src_b` is ignored.
- R10: `inv_flag` is set with the result when any taking-part lane holds a signalling NaN (fraction bit 22 = 0) in A or B. A quiet NaN (fraction bit 22 = 1) does not set it.
- R11: With LANES=16, `sae_en`=1 holds `inv_flag` low. With fewer lanes `sae_en` is ignored.
- R12: Only `pred_code` = 8'h11 performs the compare. Any other code yields zero results and no flag, while `out_valid` still follows R8.
- R13: While `rst_n` is low and after it, `out_valid`, `vec_res`, `mask_res` and `inv_flag` are zero until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and controls valid this cycle |
| pred_code | input | 8 | Predicate code; 8'h11 selects this compare |
| mask_mode | input | 1 | 1: mask result form, 0: vector result form |
| wmask_en | input | 1 | Enables the zeroing write-mask in mask form |
| wmask | input | 16 | Per-lane write-mask, bit i for lane i |
| bcst_en | input | 1 | Use `bcst_val` as operand B in every lane |
| bcst_val | input | 32 | Broadcast scalar for operand B |
| sae_en | input | 1 | Suppress the invalid flag (16-lane build only) |
| src_a | input | LANES*32 | Packed operand A, lane i at [32i+31:32i] |
| src_b | input | LANES*32 | Packed operand B, lane i at [32i+31:32i] |
| out_valid | output | 1 | Registered results valid |
| vec_res | output | LANES*32 | Vector-form result |
| mask_res | output | 16 | Mask-form result |
| inv_flag | output | 1 | Invalid-operation flag |

## Verification
The bench builds two copies side by side from the same stimulus: one with LANES=16 and one with LANES=4 fed from the low 128 bits. The 16-lane copy reaches the exception-suppress path and the full mask. The 4-lane copy shows that the mask bits above the lane count stay zero, and that the suppress input is ignored in a narrower build. Random operands mix signed zeros, infinities, denormals, both NaN kinds and equal pairs, so every branch of the sign and magnitude ordering is reached under broadcast, write-mask and both result forms.

// File: rtl/fplt_pkg.sv
`timescale 1ns/1ps
package fplt_pkg;

    localparam int FP_W        = 32;
    localparam int MASK_W      = 16;
    localparam logic [7:0] CODE_LT_OQ = 8'h11;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } cmp_state_e;

    function automatic logic fp_is_nan(input logic [FP_W-1:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    function automatic logic fp_is_snan(input logic [FP_W-1:0] v);
        return fp_is_nan(v) && !v[22];
    endfunction

endpackage

// File: rtl/fplt_bsel.sv
`timescale 1ns/1ps
module fplt_bsel
    import fplt_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W = LANES * FP_W
) (
    input  logic [VEC_W-1:0] b_in,
    input  logic             bcst_en,
    input  logic [FP_W-1:0]  bcst_val,
    output logic [VEC_W-1:0] b_eff
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign b_eff[g*FP_W +: FP_W] = bcst_en ? bcst_val : b_in[g*FP_W +: FP_W];
    end

endmodule

// File: rtl/fplt_lane.sv
`timescale 1ns/1ps
module fplt_lane
    import fplt_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic            lt,
    output logic            snan_hit
);

    logic        a_nan, b_nan;
    logic [30:0] a_mag, b_mag;
    logic        mag_lt, mag_gt, both_zero;
    logic        ordered_lt;

    assign a_nan     = fp_is_nan(op_a);
    assign b_nan     = fp_is_nan(op_b);
    assign a_mag     = op_a[30:0];
    assign b_mag     = op_b[30:0];
    assign mag_lt    = a_mag < b_mag;
    assign mag_gt    = a_mag > b_mag;
    assign both_zero = (a_mag == 31'd0) && (b_mag == 31'd0);

    // sign first, then magnitude; two negatives reverse the magnitude order
    always_comb begin
        unique case ({op_a[31], op_b[31]})
            2'b00:   ordered_lt = mag_lt;
            2'b11:   ordered_lt = mag_gt;
            2'b10:   ordered_lt = !both_zero;
            default: ordered_lt = 1'b0;
        endcase
    end

    assign lt       = !(a_nan || b_nan) && ordered_lt;
    assign snan_hit = fp_is_snan(op_a) || fp_is_snan(op_b);

    always_comb begin
        if (a_nan || b_nan) begin
            assert_nan_false_R6: assert (!lt);
        end
        if (both_zero) begin
            assert_signed_zero_R7: assert (!lt);
        end
        if (lt) begin
            assert_lt_not_ge_R1: assert (!(op_a == op_b));
        end
    end

endmodule

// File: rtl/fplt_ctrl.sv
`timescale 1ns/1ps
module fplt_ctrl
    import fplt_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W  = LANES * FP_W,
    localparam bit SAE_OK = (LANES == MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              code_ok,
    input  logic              mask_mode,
    input  logic              wmask_en,
    input  logic [MASK_W-1:0] wmask,
    input  logic              sae_en,
    input  logic [LANES-1:0]  lane_lt,
    input  logic [LANES-1:0]  lane_snan,
    output logic              out_valid,
    output logic [VEC_W-1:0]  vec_res,
    output logic [MASK_W-1:0] mask_res,
    output logic              inv_flag
);

    cmp_state_e state_q, state_d;

    logic [LANES-1:0]  active;
    logic [LANES-1:0]  hit;
    logic [VEC_W-1:0]  vec_d;
    logic [MASK_W-1:0] mask_d;
    logic              flag_d;
    logic              ctl_unused;

    assign ctl_unused = ^wmask;

    assign active = (mask_mode && wmask_en) ? wmask[LANES-1:0] : {LANES{1'b1}};
    assign hit    = lane_lt & active & {LANES{code_ok}};

    for (genvar g = 0; g < LANES; g++) begin : g_vec
        assign vec_d[g*FP_W +: FP_W] = {FP_W{hit[g] && !mask_mode}};
    end

    always_comb begin
        mask_d = '0;
        if (mask_mode) begin
            mask_d[LANES-1:0] = hit;
        end
    end

    assign flag_d = code_ok && (|(lane_snan & active)) && !(SAE_OK && sae_en);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_res  <= '0;
            mask_res <= '0;
            inv_flag <= 1'b0;
        end else if (in_valid) begin
            vec_res  <= vec_d;
            mask_res <= mask_d;
            inv_flag <= flag_d;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(vec_res) && $stable(mask_res) && $stable(inv_flag)));
    assert_wmask_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_mode && wmask_en) |=>
            ((mask_res[LANES-1:0] & ~$past(wmask[LANES-1:0])) == '0));
    assert_vec_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_mode) |=> (mask_res == '0));
    assert_mask_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_mode) |=> (vec_res == '0));

    if (SAE_OK) begin : g_sae_chk
        assert_sae_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sae_en) |=> !inv_flag);
    end

    if (LANES < MASK_W) begin : g_upper_chk
        assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            mask_res[MASK_W-1:LANES] == '0);
    end

endmodule

// File: rtl/fp32_vec_lt_cmp.sv
`timescale 1ns/1ps
module fp32_vec_lt_cmp
    import fplt_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W = LANES * FP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        pred_code,
    input  logic              mask_mode,
    input  logic              wmask_en,
    input  logic [MASK_W-1:0] wmask,
    input  logic              bcst_en,
    input  logic [FP_W-1:0]   bcst_val,
    input  logic              sae_en,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    output logic              out_valid,
    output logic [VEC_W-1:0]  vec_res,
    output logic [MASK_W-1:0] mask_res,
    output logic              inv_flag
);

    logic [VEC_W-1:0] b_eff;
    logic [LANES-1:0] lane_lt;
    logic [LANES-1:0] lane_snan;
    logic             code_ok;

    assign code_ok = (pred_code == CODE_LT_OQ);

    fplt_bsel #(.LANES(LANES)) bsel_i (
        .b_in     (src_b),
        .bcst_en  (bcst_en),
        .bcst_val (bcst_val),
        .b_eff    (b_eff)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fplt_lane lane_i (
            .op_a     (src_a[g*FP_W +: FP_W]),
            .op_b     (b_eff[g*FP_W +: FP_W]),
            .lt       (lane_lt[g]),
            .snan_hit (lane_snan[g])
        );

        assert_lane_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ((vec_res[g*FP_W +: FP_W] == '0) ||
                           (vec_res[g*FP_W +: FP_W] == '1)));
    end

    fplt_ctrl #(.LANES(LANES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .code_ok   (code_ok),
        .mask_mode (mask_mode),
        .wmask_en  (wmask_en),
        .wmask     (wmask),
        .sae_en    (sae_en),
        .lane_lt   (lane_lt),
        .lane_snan (lane_snan),
        .out_valid (out_valid),
        .vec_res   (vec_res),
        .mask_res  (mask_res),
        .inv_flag  (inv_flag)
    );

    assert_bad_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (pred_code != CODE_LT_OQ)) |=>
            ((vec_res == '0) && (mask_res == '0) && !inv_flag));
    assert_bcst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcst_en && (src_a == '0)) |=> (inv_flag == $past(fp_is_snan(bcst_val)
            && (pred_code == CODE_LT_OQ) && !(sae_en && LANES == MASK_W)
            && !(mask_mode && wmask_en && wmask[LANES-1:0] == '0))));

endmodule

// File: tb/fp32_vec_lt_cmp_tb_top.sv
`timescale 1ns/1ps
module fp32_vec_lt_cmp_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   pred_code = 8'h11;
    logic         mask_mode = 1'b0;
    logic         wmask_en = 1'b0;
    logic [15:0]  wmask = 16'hFFFF;
    logic         bcst_en = 1'b0;
    logic [31:0]  bcst_val = 32'd0;
    logic         sae_en = 1'b0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;

    logic         ov16, ov4, fl16, fl4;
    logic [511:0] vr16;
    logic [127:0] vr4;
    logic [15:0]  mr16, mr4;

    logic [31:0]  a_l [16];
    logic [31:0]  b_l [16];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fp32_vec_lt_cmp #(.LANES(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred_code(pred_code),
        .mask_mode(mask_mode), .wmask_en(wmask_en), .wmask(wmask),
        .bcst_en(bcst_en), .bcst_val(bcst_val), .sae_en(sae_en),
        .src_a(src_a), .src_b(src_b), .out_valid(ov16), .vec_res(vr16),
        .mask_res(mr16), .inv_flag(fl16)
    );

    fp32_vec_lt_cmp #(.LANES(4)) dut_n4_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred_code(pred_code),
        .mask_mode(mask_mode), .wmask_en(wmask_en), .wmask(wmask),
        .bcst_en(bcst_en), .bcst_val(bcst_val), .sae_en(sae_en),
        .src_a(src_a[127:0]), .src_b(src_b[127:0]), .out_valid(ov4), .vec_res(vr4),
        .mask_res(mr4), .inv_flag(fl4)
    );

    function automatic bit ref_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic longint ref_key(logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic void ref_calc(input int n, output logic [511:0] ev,
                                     output logic [15:0] em, output logic ef);
        logic snan_seen = 1'b0;
        ev = '0; em = '0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] bb = bcst_en ? bcst_val : b_l[i];
            bit act = (mask_mode && wmask_en) ? wmask[i] : 1'b1;
            bit lt  = !ref_nan(a_l[i]) && !ref_nan(bb) && (ref_key(a_l[i]) < ref_key(bb));
            bit h   = (pred_code == 8'h11) && act && lt;
            if (!mask_mode) ev[i*32 +: 32] = {32{h}};
            else            em[i] = h;
            if (act && ((ref_nan(a_l[i]) && !a_l[i][22]) || (ref_nan(bb) && !bb[22])))
                snan_seen = 1'b1;
        end
        ef = (pred_code == 8'h11) && snan_seen && !(sae_en && n == 16);
    endfunction

    task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one valid operation, then check both copies one edge later
    task automatic step(string req);
        logic [511:0] ev16, ev4;
        logic [15:0]  em16, em4;
        logic         ef16, ef4;
        for (int i = 0; i < 16; i++) begin
            src_a[i*32 +: 32] = a_l[i];
            src_b[i*32 +: 32] = b_l[i];
        end
        in_valid = 1'b1;
        ref_calc(16, ev16, em16, ef16);
        ref_calc(4, ev4, em4, ef4);
        @(posedge clk); #1;
        chk(req, "valid16 R8", {511'd0, ov16}, 512'd1);
        chk(req, "valid4 R8",  {511'd0, ov4},  512'd1);
        chk(req, "vec16 R2",   vr16, ev16);
        chk(req, "vec4 R2",    {384'd0, vr4}, ev4);
        chk(req, "mask16 R3",  {496'd0, mr16}, {496'd0, em16});
        chk(req, "mask4 R5",   {496'd0, mr4},  {496'd0, em4});
        chk(req, "flag16 R10", {511'd0, fl16}, {511'd0, ef16});
        chk(req, "flag4 R10",  {511'd0, fl4},  {511'd0, ef4});
    endtask

    function automatic logic [31:0] rnd_fp();
        logic s = 1'($urandom);
        case ($urandom % 9)
            0: return $urandom;
            1: return 32'h0000_0000;
            2: return 32'h8000_0000;
            3: return {s, 8'hFF, 1'b1, 22'($urandom)};
            4: return {s, 8'hFF, 1'b0, 22'($urandom) | 22'd1};
            5: return {s, 8'hFF, 23'd0};
            6: return {s, 8'h00, 23'($urandom)};
            7: return {s, 8'h7F, 2'($urandom), 21'd0};
            default: return {s, 8'($urandom % 4) + 8'h7E, 23'($urandom % 3)};
        endcase
    endfunction

    task automatic clear_ops();
        for (int i = 0; i < 16; i++) begin
            a_l[i] = 32'h3F80_0000;
            b_l[i] = 32'h3F80_0000;
        end
        pred_code = 8'h11; mask_mode = 0; wmask_en = 0; wmask = 16'hFFFF;
        bcst_en = 0; sae_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] hold_v;
        void'($urandom(32'd20240611));
        clear_ops();
        repeat (3) @(posedge clk);
        #1;
        // R13: reset state
        chk("R13", "valid", {510'd0, ov16, ov4}, 512'd0);
        chk("R13", "vec",   vr16 | {384'd0, vr4}, 512'd0);
        chk("R13", "mask/flag", {494'd0, mr16, mr4, fl16, fl4}, 512'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R13", "idle valid", {510'd0, ov16, ov4}, 512'd0);

        // R1: ordering across signs, infinity, denormals
        clear_ops();
        a_l[0] = 32'h3F80_0000; b_l[0] = 32'h4000_0000;
        a_l[1] = 32'hC000_0000; b_l[1] = 32'hBF80_0000;
        a_l[2] = 32'hBF80_0000; b_l[2] = 32'hC000_0000;
        a_l[3] = 32'h0000_0001; b_l[3] = 32'h0000_0002;
        a_l[4] = 32'hFF80_0000; b_l[4] = 32'h0000_0000;
        a_l[5] = 32'h4000_0000; b_l[5] = 32'h7F80_0000;
        a_l[6] = 32'h8000_0001; b_l[6] = 32'h0000_0000;
        step("R1");
        mask_mode = 1; step("R3");

        // R7: signed zeros
        clear_ops();
        a_l[0] = 32'h0000_0000; b_l[0] = 32'h8000_0000;
        a_l[1] = 32'h8000_0000; b_l[1] = 32'h0000_0000;
        step("R7");

        // R6 / R10: quiet NaN gives false, no flag; signalling NaN flags
        clear_ops();
        a_l[0] = 32'h7FC0_0000; b_l[0] = 32'h7F80_0000;
        a_l[1] = 32'hBF80_0000; b_l[1] = 32'hFFC0_0001;
        step("R6");
        b_l[9] = 32'h7F80_0001;
        step("R10");

        // R4: write-mask hides an sNaN lane and zeroes its result
        clear_ops();
        mask_mode = 1; wmask_en = 1; wmask = 16'hFFFE;
        a_l[0] = 32'h7F80_0005; b_l[0] = 32'h4000_0000;
        a_l[1] = 32'h3F80_0000; b_l[1] = 32'h4000_0000;
        a_l[5] = 32'h3F80_0000; b_l[5] = 32'h4000_0000;
        wmask[5] = 1'b0;
        step("R4");
        wmask_en = 0; step("R4");
        mask_mode = 0; wmask_en = 1; step("R4");

        // R11: suppression only in the 16-lane build
        clear_ops();
        a_l[0] = 32'hFF80_0001;
        sae_en = 1; step("R11");

        // R9: broadcast replaces every lane of B
        clear_ops();
        bcst_en = 1; bcst_val = 32'h4040_0000;
        for (int i = 0; i < 16; i++) begin
            a_l[i] = (i % 2 == 0) ? 32'h4000_0000 : 32'h4080_0000;
            b_l[i] = 32'h7F80_0001;
        end
        step("R9");

        // R12: other predicate codes do nothing
        clear_ops();
        a_l[0] = 32'h3F80_0000; b_l[0] = 32'h4000_0000;
        a_l[1] = 32'h7F80_0001;
        pred_code = 8'h12; step("R12");
        mask_mode = 1; pred_code = 8'h01; step("R12");

        // R5: narrow build keeps mask upper bits clear
        clear_ops();
        mask_mode = 1;
        for (int i = 0; i < 16; i++) b_l[i] = 32'h4100_0000;
        step("R5");

        // R8: valid drops and results hold
        clear_ops();
        a_l[2] = 32'h3F80_0000; b_l[2] = 32'h4000_0000;
        step("R8");
        hold_v = vr16;
        in_valid = 1'b0;
        a_l[2] = 32'h4000_0000;
        src_a = '1;
        @(posedge clk); #1;
        chk("R8", "valid low", {510'd0, ov16, ov4}, 512'd0);
        chk("R8", "hold vec", vr16, hold_v);

        // random mix
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < 16; i++) begin
                a_l[i] = rnd_fp();
                b_l[i] = ($urandom % 6 == 0) ? a_l[i] : rnd_fp();
            end
            pred_code = ($urandom % 10 == 0) ? 8'($urandom) : 8'h11;
            mask_mode = 1'($urandom);
            wmask_en  = 1'($urandom);
            wmask     = 16'($urandom);
            bcst_en   = ($urandom % 4 == 0);
            bcst_val  = rnd_fp();
            sae_en    = ($urandom % 4 == 0);
            step("R1");
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
                chk("R8", "gap valid", {510'd0, ov16, ov4}, 512'd0);
            end
        end

        in_valid = 1'b0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule